// File: doc/BRIEF.md
# Multi-Latency FP Issue Interlock

This block sits beside the decode stage of an in-order pipeline that feeds four execution units: an integer pipe (also used by loads and stores), a pipelined floating-point adder, a pipelined multiplier and a divider that takes one operation at a time. Every cycle it looks at the instruction held in decode and decides one thing: issue it now, or hold it. When it issues, it names the unit that takes the instruction. When it holds, decode keeps its instruction and fetch keeps its own.

The block keeps a countdown for each architectural register. When an instruction issues, the countdown for its destination is loaded with that producer's ready distance, and every countdown then drops by one each cycle. A consumer may issue once the countdowns of its sources are low enough. The limit is one cycle looser for a store, because a store reads its data late in the pipe. A second structure is a shift register of booked writeback slots. It holds back any issue whose writeback would land in the same cycle as one already in flight. Divides also wait while the external divider reports busy.

Top module: `fp_issue_interlock`

## Requirements
- R1: After reset no register is pending and no writeback is booked, so a valid instruction of any class issues in the first cycle it is presented, provided `div_busy` is low.
- R2: The class code on `id_class` is 0 integer, 1 load, 2 store, 3 FP add, 4 FP multiply, 5 FP divide. Codes 6 and 7 behave as integer. A consumer that is not a store issues no earlier than (producer ready distance) intervening cycles after the producer that writes one of its sources. The ready distance is ADD_STAGES-1 for an FP add, MUL_STAGES-1 for an FP multiply, DIV_LAT-1 for a divide, 1 for a load and 0 for an integer operation.
- R3: A store consumer needs one intervening cycle fewer than R2 gives, with a floor of zero. An FP add feeding a store needs 2 cycles, and a load feeding a store needs 0.
- R4: A load feeding an FP or integer operation needs exactly 1 intervening cycle. An integer result feeding an integer operation issues back to back.
- R5: While `div_busy` is high, a valid divide is held. Other classes ignore `div_busy`.
- R6: Both sources, `id_src1` and `id_src2`, are checked. A producer's pending countdown delays only consumers that read its destination register, and has no effect on any other register.
- R7: An instruction writes back ADD_STAGES cycles after issue for an FP add, MUL_STAGES for a multiply, DIV_LAT for a divide, and 1 for integer and load. A store does not write back. An issue whose writeback cycle is already booked is held until the slot is free.
- R8: `issue_sel` is one-hot with bit 0 for the integer pipe (integer, load, store), bit 1 for the adder, bit 2 for the multiplier and bit 3 for the divider. It is nonzero only in a cycle where a valid instruction issues.
- R9: `stall` is low whenever `id_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_class | input | 3 | Decoded instruction class |
| id_src1 | input | RW | First source register |
| id_src2 | input | RW | Second source register |
| id_dst | input | RW | Destination register |
| div_busy | input | 1 | Divider cannot take an operation |
| stall | output | 1 | Hold decode and fetch this cycle |
| issue_sel | output | 4 | One-hot unit taking the issued instruction |

## Verification
The hardest situation to reach is a writeback clash between two independent instructions. It needs a long-latency producer and a shorter one presented at exactly the cycle offset where their completion cycles coincide, with no data dependence to hide the clash. The bench issues a multiply or divide, then waits a computed number of idle cycles before presenting an unrelated add or integer operation. It does this both at the colliding offset and one cycle either side. The producer/consumer latency matrix is swept over every pair of classes, with an idle gap that drains all state between pairs.

// File: rtl/fpil_pkg.sv
package fpil_pkg;

    typedef enum logic [2:0] {
        OP_INT   = 3'd0,
        OP_LOAD  = 3'd1,
        OP_STORE = 3'd2,
        OP_FADD  = 3'd3,
        OP_FMUL  = 3'd4,
        OP_FDIV  = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } op_class_e;

    localparam int UNIT_N   = 4;
    localparam int UNIT_INT = 0;
    localparam int UNIT_ADD = 1;
    localparam int UNIT_MUL = 2;
    localparam int UNIT_DIV = 3;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/fpil_pend_table.sv
module fpil_pend_table #(
    parameter int NREG = 32,
    parameter int CW   = 5,
    localparam int RW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_idx,
    input  logic [CW-1:0] wr_val,
    input  logic [RW-1:0] rd_a,
    input  logic [RW-1:0] rd_b,
    output logic [CW-1:0] cnt_a,
    output logic [CW-1:0] cnt_b
);
    logic [CW-1:0] cnt [NREG];

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt[r] <= '0;
            else if (wr_en && wr_idx == RW'(r))
                cnt[r] <= wr_val;
            else if (cnt[r] != '0)
                cnt[r] <= cnt[r] - CW'(1);
        end
    end

    assign cnt_a = cnt[rd_a];
    assign cnt_b = cnt[rd_b];
endmodule

// File: rtl/fpil_wb_slots.sv
module fpil_wb_slots #(
    parameter int DEPTH = 25,
    localparam int OW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          book_en,
    input  logic [OW-1:0] book_off,
    input  logic [OW-1:0] probe_off,
    output logic          probe_busy
);
    // slot[k] set: a writeback lands k cycles after the current one
    logic [DEPTH-1:0] slot;

    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        logic nxt;
        if (k == DEPTH - 1) begin : g_top
            assign nxt = 1'b0;
        end else begin : g_mid
            assign nxt = slot[k+1];
        end
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot[k] <= 1'b0;
            else
                slot[k] <= nxt | (book_en && book_off == OW'(k + 1));
        end
    end

    always_comb begin
        probe_busy = 1'b0;
        for (int k = 1; k < DEPTH; k++)
            if (probe_off == OW'(k))
                probe_busy = slot[k];
    end
endmodule

// File: rtl/fp_issue_interlock.sv
module fp_issue_interlock
    import fpil_pkg::*;
#(
    parameter int NREG       = 32,
    parameter int ADD_STAGES = 4,
    parameter int MUL_STAGES = 7,
    parameter int DIV_LAT    = 24,
    localparam int RW        = $clog2(NREG),
    localparam int MAXOFF    = max3(ADD_STAGES, MUL_STAGES, DIV_LAT),
    localparam int DEPTH     = MAXOFF + 1,
    localparam int OW        = $clog2(DEPTH),
    localparam int CW        = $clog2(MAXOFF + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_valid,
    input  logic [2:0]        id_class,
    input  logic [RW-1:0]     id_src1,
    input  logic [RW-1:0]     id_src2,
    input  logic [RW-1:0]     id_dst,
    input  logic              div_busy,
    output logic              stall,
    output logic [UNIT_N-1:0] issue_sel
);
    op_class_e     cls;
    logic [CW-1:0] ready_dist;
    logic [OW-1:0] wb_off;
    logic          writes;
    logic [UNIT_N-1:0] unit;
    logic [CW-1:0] slack;
    logic [CW-1:0] cnt_a, cnt_b;
    logic          hold_raw, hold_div, hold_wb, issue;

    assign cls = op_class_e'(id_class);

    always_comb begin
        ready_dist = '0;
        wb_off     = OW'(1);
        writes     = 1'b1;
        unit       = UNIT_N'(1) << UNIT_INT;
        unique case (cls)
            OP_LOAD: begin
                ready_dist = CW'(1);
            end
            OP_STORE: begin
                wb_off = '0;
                writes = 1'b0;
            end
            OP_FADD: begin
                ready_dist = CW'(ADD_STAGES - 1);
                wb_off     = OW'(ADD_STAGES);
                unit       = UNIT_N'(1) << UNIT_ADD;
            end
            OP_FMUL: begin
                ready_dist = CW'(MUL_STAGES - 1);
                wb_off     = OW'(MUL_STAGES);
                unit       = UNIT_N'(1) << UNIT_MUL;
            end
            OP_FDIV: begin
                ready_dist = CW'(DIV_LAT - 1);
                wb_off     = OW'(DIV_LAT);
                unit       = UNIT_N'(1) << UNIT_DIV;
            end
            default: begin
                ready_dist = '0;
            end
        endcase
    end

    // stores read their data one cycle later than other consumers
    assign slack = (cls == OP_STORE) ? CW'(1) : '0;

    fpil_pend_table #(.NREG(NREG), .CW(CW)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (issue && writes),
        .wr_idx (id_dst),
        .wr_val (ready_dist),
        .rd_a   (id_src1),
        .rd_b   (id_src2),
        .cnt_a  (cnt_a),
        .cnt_b  (cnt_b)
    );

    fpil_wb_slots #(.DEPTH(DEPTH)) u_wb (
        .clk        (clk),
        .rst_n      (rst_n),
        .book_en    (issue && writes),
        .book_off   (wb_off),
        .probe_off  (wb_off),
        .probe_busy (hold_wb)
    );

    assign hold_raw  = (cnt_a > slack) || (cnt_b > slack);
    assign hold_div  = (cls == OP_FDIV) && div_busy;
    assign stall     = id_valid && (hold_raw || hold_div || (writes && hold_wb));
    assign issue     = id_valid && !stall;
    assign issue_sel = issue ? unit : '0;
endmodule

// File: rtl/fpil_chk.sv
module fpil_chk #(
    parameter int RW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          id_valid,
    input logic [2:0]    id_class,
    input logic [RW-1:0] id_src1,
    input logic [RW-1:0] id_dst,
    input logic          div_busy,
    input logic          stall,
    input logic [3:0]    issue_sel
);
    logic          prev_add;
    logic [RW-1:0] prev_dst;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_add <= 1'b0;
            prev_dst <= '0;
        end else begin
            prev_add <= issue_sel[1];
            prev_dst <= id_dst;
        end
    end

    // R8
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(issue_sel));

    // R8
    sel_quiet_on_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> issue_sel == 4'b0);

    // R9
    idle_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |-> !stall);

    // R5
    div_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && id_class == 3'd5 && div_busy) |-> stall);

    // R2
    add_chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_add && id_valid && (id_class == 3'd3 || id_class == 3'd4)
         && id_src1 == prev_dst) |-> stall);
endmodule

bind fp_issue_interlock fpil_chk #(.RW(RW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .id_valid  (id_valid),
    .id_class  (id_class),
    .id_src1   (id_src1),
    .id_dst    (id_dst),
    .div_busy  (div_busy),
    .stall     (stall),
    .issue_sel (issue_sel)
);

// File: tb/sim_fp_issue_interlock.sv
module sim_fp_issue_interlock;
    localparam int NREG = 8;
    localparam int ADDS = 4;
    localparam int MULS = 7;
    localparam int DIVL = 8;
    localparam int RW   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          id_valid = 1'b0;
    logic [2:0]    id_class = 3'd0;
    logic [RW-1:0] id_src1 = '0, id_src2 = '0, id_dst = '0;
    logic          div_busy = 1'b0;
    logic          stall;
    logic [3:0]    issue_sel;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fp_issue_interlock #(.NREG(NREG), .ADD_STAGES(ADDS), .MUL_STAGES(MULS),
                         .DIV_LAT(DIVL)) u0 (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_class(id_class),
        .id_src1(id_src1), .id_src2(id_src2), .id_dst(id_dst),
        .div_busy(div_busy), .stall(stall), .issue_sel(issue_sel));

    function automatic int ready_of(input int c);
        case (c)
            1: return 1;
            3: return ADDS - 1;
            4: return MULS - 1;
            5: return DIVL - 1;
            default: return 0;
        endcase
    endfunction

    function automatic logic [3:0] unit_of(input int c);
        case (c)
            3: return 4'b0010;
            4: return 4'b0100;
            5: return 4'b1000;
            default: return 4'b0001;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic present(input int c, input int s1, input int s2, input int d);
        @(negedge clk);
        id_valid = 1'b1; id_class = 3'(c);
        id_src1 = RW'(s1); id_src2 = RW'(s2); id_dst = RW'(d);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            id_valid = 1'b0;
        end
    endtask

    // hold the presented instruction until it issues; returns stall cycles
    task automatic wait_issue(output int n, output logic [3:0] sel);
        n = 0;
        while (stall && n < 100) begin
            @(negedge clk); #1;
            n++;
        end
        sel = issue_sel;
    endtask

    task automatic pair(input string req, input int p, input int c, input int exp);
        int n; logic [3:0] sel;
        present(p, 6, 7, 3);
        check(req, int'(stall), 0);
        present(c, 3, 7, 4);
        wait_issue(n, sel);
        check(req, n, exp);
        check("R8", int'(sel), int'(unit_of(c)));
        idle(DIVL + 4);
    endtask

    // independent follower presented after gap idle cycles
    task automatic clash(input string req, input int p, input int gap,
                         input int c, input int exp);
        int n; logic [3:0] sel;
        present(p, 6, 7, 3);
        idle(gap);
        present(c, 5, 6, 4);
        wait_issue(n, sel);
        check(req, n, exp);
        idle(DIVL + 4);
    endtask

    initial begin
        int n; logic [3:0] sel;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: fresh state, every class issues immediately
        for (int c = 0; c < 8; c++) begin
            present(c, 1, 2, 0);
            check("R1", int'(stall), 0);
            check("R8", int'(issue_sel), int'(unit_of(c)));
            idle(DIVL + 4);
        end

        // R2 R3 R4: full producer/consumer sweep
        for (int p = 0; p < 6; p++) begin
            if (p == 2) continue;
            for (int c = 0; c < 6; c++) begin
                int e;
                e = ready_of(p) - (c == 2 ? 1 : 0);
                if (e < 0) e = 0;
                pair((c == 2) ? "R3" : ((p <= 1) ? "R4" : "R2"), p, c, e);
            end
        end

        // R6: second source also checked; unrelated register not delayed
        present(3, 6, 7, 3);
        present(3, 7, 3, 4);
        wait_issue(n, sel);
        check("R6", n, ADDS - 1);
        idle(DIVL + 4);
        present(4, 6, 7, 3);
        present(3, 5, 6, 4);
        check("R6", int'(stall), 0);
        idle(DIVL + 4);

        // R7: writeback clashes around the colliding offset
        clash("R7", 4, MULS - ADDS - 2, 3, 0);
        clash("R7", 4, MULS - ADDS - 1, 3, 1);
        clash("R7", 4, MULS - ADDS,     3, 0);
        clash("R7", 4, MULS - 2,        0, 1);
        clash("R7", 5, 0,               4, 1);
        clash("R7", 4, MULS - 2,        2, 0);

        // R5: divider busy holds divides only
        div_busy = 1'b1;
        present(3, 6, 7, 2);
        check("R5", int'(stall), 0);
        present(5, 6, 7, 2);
        for (int i = 0; i < 3; i++) begin
            check("R5", int'(stall), 1);
            @(negedge clk); #1;
        end
        div_busy = 1'b0;
        #1;
        check("R5", int'(stall), 0);
        check("R8", int'(issue_sel), 4'b1000);

        // R9: pending state present but nothing valid
        @(negedge clk);
        id_valid = 1'b0; id_src1 = 3'd2; #1;
        check("R9", int'(stall), 0);
        check("R9", int'(issue_sel), 0);
        idle(DIVL + 4);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_900_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule